// File: doc/BRIEF.md
# PCI Interrupt Router and Trigger Unit

This block takes interrupt requests raised by PCI devices, identified by the slot they sit in and the interrupt pin they use (0 to 3). It translates each request into a numbered internal interrupt line through a fixed, slot-dependent routing table. Add-in slots get a rotating pin assignment, so that neighbouring cards spread their pins over different lines.

The line chosen by the route selects one bit of a 32-bit edge-select word and one bit of a 32-bit polarity word. Both words come from the register file. In edge mode, a change of the request level on that line yields a single one-clock pulse on the CPU interrupt output. In level mode, the CPU interrupt output is set from the polarity bit and holds that value until the next request. The block accepts at most one request per clock through a valid strobe, and it reports the line number of the most recent request.

Top module: `irq_router_trig`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `cpu_irq` is 0 and `line_num` is 0, and every remembered line level is 0.
- R2: A request from slot 5 with pin n maps to line 32 + n.
- R3: A request from slot 6 maps to line 36 and a request from slot 7 maps to line 37, whatever the pin.
- R4: A request from slot s in 8..12 with pin n maps to line 32 + 6 + (s − 8) + n.
- R5: A request from any other slot yields the pin number itself (0..3) as `line_num`, untranslated.
- R6: When the edge-select bit of the selected index is 1 and the request level differs from the stored level, `cpu_irq` is 1 for exactly the one cycle after the request, then 0 if no further request arrives.
- R7: When the edge-select bit of the selected index is 0, `cpu_irq` equals that index's polarity bit from the cycle after the request, and it holds while no request arrives.
- R8: `line_num` takes the mapped line in the cycle after a valid request and is unchanged in any cycle that follows a clock with no request.
- R9: The selected configuration index is (line − 32) modulo 32; bits of `edge_cfg` and `pol_cfg` at other indexes have no effect on the result.
- R10: Every request stores its level for its index. An edge-mode request whose level equals the stored level for that index gives `cpu_irq` 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One request this cycle |
| req_slot | input | 5 | Slot number of the requesting device |
| req_pin | input | 2 | Interrupt pin of the device, 0..3 |
| req_level | input | 1 | Request level carried by the request |
| edge_cfg | input | 32 | Per-index edge select, 1 = pulse mode |
| pol_cfg | input | 32 | Per-index polarity used in level mode |
| cpu_irq | output | 1 | Registered CPU interrupt line |
| line_num | output | 6 | Mapped line of the latest request |

## Verification
Several properties are checked on every cycle. The bound checker confirms that the reported line holds between requests and that untranslated lines stay in the pin range. It also confirms that a level-mode result matches the polarity bit of the reported line and then holds, and that a pulse drops after one cycle without a new request. Other behaviour can be shown only by the bench's scenarios: the exact routing table per slot, the isolation of the selected configuration bit from its neighbours, and the change detection against the remembered level of each index. The bench covers these by sweeping all 32 slots and 4 pins, and it keeps an arithmetic model of the expected line and the per-index levels.

// File: rtl/irq_rt_pkg.sv
package irq_rt_pkg;

  // Slot numbers with a dedicated route
  localparam int MULTI_SLOT   = 5;
  localparam int GFX_SLOT     = 6;
  localparam int NIC_SLOT     = 7;
  localparam int ADDIN_FIRST  = 8;
  localparam int ADDIN_LAST   = 12;

  // Internal indexes those slots land on
  localparam int GFX_INDEX    = 4;
  localparam int NIC_INDEX    = 5;
  localparam int ADDIN_INDEX0 = 6;

  typedef enum logic [2:0] {
    RC_MULTI = 3'd0,
    RC_GFX   = 3'd1,
    RC_NIC   = 3'd2,
    RC_ADDIN = 3'd3,
    RC_PASS  = 3'd4
  } route_cls_e;

endpackage

// File: rtl/irq_slot_map.sv
module irq_slot_map
  import irq_rt_pkg::*;
#(
  parameter int SLOT_W    = 5,
  parameter int PIN_W     = 2,
  parameter int LINE_BASE = 32,
  parameter int LINE_W    = 6,
  parameter int IDX_W     = 5
) (
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [PIN_W-1:0]  pin_i,
  output logic [LINE_W-1:0] line_o,
  output logic [IDX_W-1:0]  idx_o
);

  localparam int PIN_CNT = 1 << PIN_W;

  route_cls_e        cls;
  logic [LINE_W-1:0] offset;
  logic [LINE_W-1:0] pin_ext;

  assign pin_ext = LINE_W'(pin_i);

  // Classify the slot
  always_comb begin
    if (slot_i == SLOT_W'(MULTI_SLOT)) begin
      cls = RC_MULTI;
    end else if (slot_i == SLOT_W'(GFX_SLOT)) begin
      cls = RC_GFX;
    end else if (slot_i == SLOT_W'(NIC_SLOT)) begin
      cls = RC_NIC;
    end else if ((slot_i >= SLOT_W'(ADDIN_FIRST)) && (slot_i <= SLOT_W'(ADDIN_LAST))) begin
      cls = RC_ADDIN;
    end else begin
      cls = RC_PASS;
    end
  end

  // Offset above the base for routed classes
  always_comb begin
    case (cls)
      RC_MULTI: offset = LINE_W'(int'(pin_i) % PIN_CNT);
      RC_GFX:   offset = LINE_W'(GFX_INDEX);
      RC_NIC:   offset = LINE_W'(NIC_INDEX);
      RC_ADDIN: offset = LINE_W'(ADDIN_INDEX0) + LINE_W'(slot_i)
                         - LINE_W'(ADDIN_FIRST) + pin_ext;
      default:  offset = '0;
    endcase
  end

  always_comb begin
    if (cls == RC_PASS) begin
      line_o = pin_ext;
    end else begin
      line_o = LINE_W'(LINE_BASE) + offset;
    end
  end

  // Index into the configuration words: line minus base, wrapped
  assign idx_o = IDX_W'(line_o - LINE_W'(LINE_BASE));

endmodule

// File: rtl/irq_level_track.sv
module irq_level_track #(
  parameter int NUM_LINES = 32,
  parameter int IDX_W     = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_level_i,
  output logic             changed_o
);

  logic [NUM_LINES-1:0] lvl_q;
  logic [NUM_LINES-1:0] lvl_d;

  genvar g;
  generate
    for (g = 0; g < NUM_LINES; g++) begin : g_line
      logic hit;
      assign hit = wr_en_i && (wr_idx_i == IDX_W'(g));

      always_comb begin
        lvl_d[g] = hit ? wr_level_i : lvl_q[g];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          lvl_q[g] <= 1'b0;
        end else if (hit) begin
          lvl_q[g] <= lvl_d[g];
        end
      end
    end
  endgenerate

  assign changed_o = wr_level_i != lvl_q[wr_idx_i];

endmodule

// File: rtl/irq_trigger.sv
module irq_trigger #(
  parameter int LINE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic              edge_bit_i,
  input  logic              pol_bit_i,
  input  logic              changed_i,
  output logic              irq_o,
  output logic [LINE_W-1:0] line_o
);

  logic              irq_q, irq_d;
  logic              pulse_q, pulse_d;
  logic [LINE_W-1:0] line_q, line_d;

  // Next state
  always_comb begin
    if (valid_i) begin
      line_d  = line_i;
      pulse_d = edge_bit_i;
      irq_d   = edge_bit_i ? changed_i : pol_bit_i;
    end else begin
      line_d  = line_q;
      pulse_d = pulse_q;
      irq_d   = pulse_q ? 1'b0 : irq_q;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q   <= 1'b0;
      pulse_q <= 1'b0;
      line_q  <= '0;
    end else begin
      irq_q   <= irq_d;
      pulse_q <= pulse_d;
      if (valid_i) begin
        line_q <= line_d;
      end
    end
  end

  assign irq_o  = irq_q;
  assign line_o = line_q;

endmodule

// File: rtl/irq_router_trig.sv
module irq_router_trig #(
  parameter int SLOT_W    = 5,
  parameter int PIN_W     = 2,
  parameter int LINE_BASE = 32,
  parameter int NUM_LINES = 32,
  parameter int LINE_W    = $clog2(LINE_BASE + NUM_LINES),
  parameter int IDX_W     = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [SLOT_W-1:0]    req_slot,
  input  logic [PIN_W-1:0]     req_pin,
  input  logic                 req_level,
  input  logic [NUM_LINES-1:0] edge_cfg,
  input  logic [NUM_LINES-1:0] pol_cfg,
  output logic                 cpu_irq,
  output logic [LINE_W-1:0]    line_num
);

  logic [LINE_W-1:0] map_line;
  logic [IDX_W-1:0]  map_idx;
  logic              lvl_changed;

  irq_slot_map #(
    .SLOT_W    (SLOT_W),
    .PIN_W     (PIN_W),
    .LINE_BASE (LINE_BASE),
    .LINE_W    (LINE_W),
    .IDX_W     (IDX_W)
  ) u_map (
    .slot_i (req_slot),
    .pin_i  (req_pin),
    .line_o (map_line),
    .idx_o  (map_idx)
  );

  irq_level_track #(
    .NUM_LINES (NUM_LINES),
    .IDX_W     (IDX_W)
  ) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en_i    (req_valid),
    .wr_idx_i   (map_idx),
    .wr_level_i (req_level),
    .changed_o  (lvl_changed)
  );

  irq_trigger #(
    .LINE_W (LINE_W)
  ) u_trig (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid_i    (req_valid),
    .line_i     (map_line),
    .edge_bit_i (edge_cfg[map_idx]),
    .pol_bit_i  (pol_cfg[map_idx]),
    .changed_i  (lvl_changed),
    .irq_o      (cpu_irq),
    .line_o     (line_num)
  );

endmodule

// File: rtl/irq_router_trig_chk.sv
module irq_router_trig_chk #(
  parameter int PIN_W     = 2,
  parameter int LINE_BASE = 32,
  parameter int NUM_LINES = 32,
  parameter int LINE_W    = 6,
  parameter int IDX_W     = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic [NUM_LINES-1:0] edge_cfg,
  input logic [NUM_LINES-1:0] pol_cfg,
  input logic                 cpu_irq,
  input logic [LINE_W-1:0]    line_num
);

  localparam int PIN_CNT = 1 << PIN_W;

  logic [IDX_W-1:0] ci;
  assign ci = IDX_W'(line_num - LINE_W'(LINE_BASE));

  // R8: line holds after an idle clock
  a_r8_line_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(line_num));

  // R5: lines below the base come only from untranslated pins
  a_r5_pass_range: assert property (@(posedge clk) disable iff (!rst_n)
    (line_num < LINE_W'(LINE_BASE)) |-> (line_num < LINE_W'(PIN_CNT)));

  // R7: level-mode result follows the polarity bit of the reported line
  a_r7_level_value: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(req_valid) && $stable(edge_cfg) && $stable(pol_cfg) && !edge_cfg[ci])
      |-> (cpu_irq == pol_cfg[ci]));

  // R7: level-mode result holds while idle
  a_r7_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(req_valid) && $stable(edge_cfg) && !edge_cfg[ci] && !req_valid)
      |=> $stable(cpu_irq));

  // R6: an edge-mode pulse lasts one cycle
  a_r6_pulse_drop: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(req_valid) && $stable(edge_cfg) && edge_cfg[ci] && !req_valid)
      |=> !cpu_irq);

endmodule

bind irq_router_trig irq_router_trig_chk #(
  .PIN_W     (PIN_W),
  .LINE_BASE (LINE_BASE),
  .NUM_LINES (NUM_LINES),
  .LINE_W    (LINE_W),
  .IDX_W     (IDX_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .edge_cfg  (edge_cfg),
  .pol_cfg   (pol_cfg),
  .cpu_irq   (cpu_irq),
  .line_num  (line_num)
);

// File: tb/sim_irq_router_trig.sv
`timescale 1ns/1ps
module sim_irq_router_trig;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [4:0]  req_slot;
  logic [1:0]  req_pin;
  logic        req_level;
  logic [31:0] edge_cfg;
  logic [31:0] pol_cfg;
  logic        cpu_irq;
  logic [5:0]  line_num;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit model_lvl [32];

  irq_router_trig u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_slot  (req_slot),
    .req_pin   (req_pin),
    .req_level (req_level),
    .edge_cfg  (edge_cfg),
    .pol_cfg   (pol_cfg),
    .cpu_irq   (cpu_irq),
    .line_num  (line_num)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_line(input int s, input int p);
    if (s == 5) return 32 + p;
    if (s == 6) return 36;
    if (s == 7) return 37;
    if (s >= 8 && s <= 12) return 32 + 6 + (s - 8) + p;
    return p;
  endfunction

  function automatic string map_tag(input int s);
    if (s == 5) return "R2";
    if (s == 6 || s == 7) return "R3";
    if (s >= 8 && s <= 12) return "R4";
    return "R5";
  endfunction

  task automatic send(input int s, input int p, input bit lvl,
                      input logic [31:0] e, input logic [31:0] pl);
    @(negedge clk);
    req_valid = 1'b1;
    req_slot  = 5'(s);
    req_pin   = 2'(p);
    req_level = lvl;
    edge_cfg  = e;
    pol_cfg   = pl;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_slot = '0; req_pin = '0;
    req_level = 1'b0; edge_cfg = '0; pol_cfg = '0;
    for (int i = 0; i < 32; i++) model_lvl[i] = 1'b0;
    repeat (3) @(negedge clk);
    chk(cpu_irq == 1'b0, "R1 irq in reset", cpu_irq, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cpu_irq == 1'b0, "R1 irq after reset", cpu_irq, 0);
    chk(line_num == 6'd0, "R1 line after reset", line_num, 0);

    for (int s = 0; s < 32; s++) begin
      for (int p = 0; p < 4; p++) begin
        int ln;
        int ix;
        bit lv;
        logic [31:0] one;
        ln  = exp_line(s, p);
        ix  = (ln - 32) & 31;
        one = 32'd1 << ix;

        // Level mode, polarity 1, neighbours in edge mode (R7, R9)
        lv = bit'((s ^ p) & 1);
        send(s, p, lv, ~one, one);
        model_lvl[ix] = lv;
        chk(int'(line_num) == ln, {map_tag(s), " mapped line"}, line_num, ln);
        chk(cpu_irq == 1'b1, "R7 R9 level pol=1", cpu_irq, 1);
        @(negedge clk);
        chk(cpu_irq == 1'b1, "R7 level hold", cpu_irq, 1);
        chk(int'(line_num) == ln, "R8 line hold", line_num, ln);

        // Level mode, polarity 0, neighbours polarity 1 (R7, R9)
        send(s, p, lv, ~one, ~one);
        chk(cpu_irq == 1'b0, "R7 R9 level pol=0", cpu_irq, 0);

        // Edge mode with a changed level (R6)
        lv = !model_lvl[ix];
        send(s, p, lv, one, 32'd0);
        model_lvl[ix] = lv;
        chk(cpu_irq == 1'b1, "R6 pulse", cpu_irq, 1);
        @(negedge clk);
        chk(cpu_irq == 1'b0, "R6 pulse one wide", cpu_irq, 0);
        chk(int'(line_num) == ln, "R8 line hold after pulse", line_num, ln);

        // Edge mode with the same level (R10)
        send(s, p, lv, one, 32'hFFFF_FFFF);
        chk(cpu_irq == 1'b0, "R10 no pulse on same level", cpu_irq, 0);
      end
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule